// File: doc/BRIEF.md
# Iterative RC5-32/12 Block Cipher Core

This core encrypts or decrypts one 64-bit block with the RC5 cipher (32-bit words, 12 rounds by default). The block is split into two words: A sits in bits 31:0 and B in bits 63:32. A single half-round circuit is reused for every step in both directions. Each round therefore costs two clock cycles, one per word, and the two working registers trade places after every step. `in_mode` = 0 selects encryption and `in_mode` = 1 selects decryption.

The expanded key table lives outside the core. The core presents a table index on `key_idx` and expects the matching 32-bit subkey on `key_word` in the same cycle, so the table must be read combinationally. Encryption first adds S[0] to A and S[1] to B, then runs rounds 1 to 12. Decryption runs rounds 12 down to 1 and finishes by subtracting S[1] from B and S[0] from A.

Input rules: a block is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a block is being processed. Output rules: `out_valid` stays high, with `out_block` stable, until an edge where `out_ready` is high or until a new block is accepted. A result that has not been collected is dropped when the next block is accepted.

Top module: `rc5_iter_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With mode 0, `out_block` is the RC5 encryption of `in_block`. The core first adds S[0] to A and S[1] to B. Each round i (1 to 12) then computes A = ((A xor B) rotl B) + S[2i] followed by B = ((B xor A) rotl A) + S[2i+1]. A is in bits 31:0 and B is in bits 63:32, for both input and output.
- R3: With mode 1, `out_block` is the RC5 decryption of `in_block`. Each round i (12 down to 1) computes B = ((B - S[2i+1]) rotr A) xor A followed by A = ((A - S[2i]) rotr B) xor B. The core then computes B -= S[1] and A -= S[0]. Decrypting a ciphertext gives back the plaintext.
- R4: `out_valid` rises exactly 2*ROUNDS+2 (26) clock edges after the edge that accepts the block. `in_ready` is low from the accepting edge until that point.
- R5: `in_valid` asserted while `in_ready` is low has no effect: the running block's result is unchanged whatever `in_block` and `in_mode` carry.
- R6: During step n (n = 0 to 25, counted from the cycle after acceptance), `key_idx` is n in encryption and 25 - n in decryption.
- R7: Every rotation amount is taken from the low 5 bits of the controlling word only. Words whose low 5 bits are zero produce no rotation, whatever their upper bits hold.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_block` stays stable. After an edge with `out_ready` high, `out_valid` is 0.
- R9: Accepting a new block clears a pending `out_valid` on that same edge.
- R10: `in_ready` is 1 in the first cycle in which `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Core can take a block (idle) |
| in_mode | input | 1 | 0 encrypt, 1 decrypt |
| in_block | input | 64 | Input block, A in bits 31:0, B in bits 63:32 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_block | output | 64 | Result block, same word layout |
| key_idx | output | 5 | Subkey table index for the current step |
| key_word | input | 32 | Subkey S[key_idx], valid in the same cycle |

## Verification
The hardest situations to reach from the ports both depend on when the environment acts relative to the core. One is a second offer that arrives in the middle of a run, which must be ignored. The other is a fresh block that arrives while an earlier result has not yet been collected. The stimulus reaches the first by driving `in_valid` with a corrupted block and the opposite mode partway through a run, then comparing the untouched result with the reference. It reaches the second by leaving `out_ready` low after a completion and launching the next block straight away. The 5-bit rotation limit is reached with directed words whose upper bits are set and whose low 5 bits are zero or all ones. These are mixed with seeded random blocks and key tables, and with the published all-zero-key test vector.

// File: rtl/rc5_iter_pkg.sv
package rc5_iter_pkg;
  // direction of operation, encoded as the mode pin
  typedef enum logic {
    RC5_ENC = 1'b0,
    RC5_DEC = 1'b1
  } rc5_dir_e;
endpackage

// File: rtl/rc5_rotator.sv
// Bidirectional barrel rotator: log2(WORD_W) stages of fixed left rotations.
// A right rotation by s is performed as a left rotation by (-s) mod WORD_W.
module rc5_rotator #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]         data_i,
  input  logic [$clog2(WORD_W)-1:0] amt_i,
  input  logic                      right_i,
  output logic [WORD_W-1:0]         data_o
);
  localparam int SH_W = $clog2(WORD_W);

  logic [SH_W-1:0]   amt_eff;
  logic [WORD_W-1:0] stage [SH_W+1];

  assign amt_eff  = right_i ? (SH_W'(0) - amt_i) : amt_i;
  assign stage[0] = data_i;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int D = 1 << g;
    assign stage[g+1] = amt_eff[g] ?
                        {stage[g][WORD_W-1-D:0], stage[g][WORD_W-1 -: D]} :
                        stage[g];
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/rc5_halfstep.sv
// One half-round for either direction. The rotator is shared; the subtract
// sits ahead of it (decrypt) and the add behind it (encrypt), keeping the
// path acyclic. Whitening steps bypass the rotator.
module rc5_halfstep
  import rc5_iter_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] x_i,      // word being updated
  input  logic [WORD_W-1:0] y_i,      // controlling word
  input  logic [WORD_W-1:0] key_i,
  input  rc5_dir_e          dir_i,
  input  logic              whiten_i,
  output logic [WORD_W-1:0] nxt_o
);
  localparam int SH_W = $clog2(WORD_W);

  logic [WORD_W-1:0] pre_diff;
  logic [WORD_W-1:0] rot_in;
  logic [WORD_W-1:0] rot_out;
  logic [WORD_W-1:0] post_sum;
  logic [WORD_W-1:0] dec_val;
  logic              go_right;

  assign go_right = (dir_i == RC5_DEC);
  assign pre_diff = x_i - key_i;
  assign rot_in   = go_right ? pre_diff : (x_i ^ y_i);

  rc5_rotator #(.WORD_W(WORD_W)) u_rot (
    .data_i  (rot_in),
    .amt_i   (y_i[SH_W-1:0]),
    .right_i (go_right),
    .data_o  (rot_out)
  );

  assign post_sum = (whiten_i ? x_i : rot_out) + key_i;
  assign dec_val  = whiten_i ? pre_diff : (rot_out ^ y_i);
  assign nxt_o    = go_right ? dec_val : post_sum;
endmodule

// File: rtl/rc5_stepper.sv
// Step sequencer: counts STEPS half-steps after a launch.
module rc5_stepper #(
  parameter int STEPS = 26,
  parameter int IDX_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] step_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] FINAL = IDX_W'(STEPS - 1);

  assign last_o = busy_o && (step_o == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      step_o <= '0;
    end else if (launch_i) begin
      busy_o <= 1'b1;
      step_o <= '0;
    end else if (busy_o) begin
      if (last_o) busy_o <= 1'b0;
      else        step_o <= step_o + 1'b1;
    end
  end
endmodule

// File: rtl/rc5_iter_core.sv
// Iterative RC5 core: one half-step per cycle, working registers swap each step.
// Encrypt: x=A, y=B. Decrypt: x=B, y=A. Steps 0..2R+1 use key index n (enc)
// or 2R+1-n (dec); whitening occupies the first two (enc) or last two (dec).
module rc5_iter_core
  import rc5_iter_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 12,
  localparam int STEPS = 2 * ROUNDS + 2,
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_mode,
  input  logic [2*WORD_W-1:0] in_block,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*WORD_W-1:0] out_block,
  output logic [IDX_W-1:0]    key_idx,
  input  logic [WORD_W-1:0]   key_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);
  localparam logic [IDX_W-1:0] TWO      = IDX_W'(2);
  localparam logic [IDX_W-1:0] TAIL     = IDX_W'(STEPS - 2);

  logic              busy;
  logic              last_step;
  logic [IDX_W-1:0]  step;
  logic              accept;
  logic              whiten;
  rc5_dir_e          mode_q;
  logic [WORD_W-1:0] x_q, y_q, nxt;
  logic [WORD_W-1:0] word_a, word_b;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign word_a   = in_block[WORD_W-1:0];
  assign word_b   = in_block[2*WORD_W-1:WORD_W];

  rc5_stepper #(.STEPS(STEPS), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (accept),
    .busy_o   (busy),
    .step_o   (step),
    .last_o   (last_step)
  );

  assign whiten  = (mode_q == RC5_DEC) ? (step >= TAIL) : (step < TWO);
  assign key_idx = (mode_q == RC5_DEC) ? (LAST_IDX - step) : step;

  rc5_halfstep #(.WORD_W(WORD_W)) u_step (
    .x_i      (x_q),
    .y_i      (y_q),
    .key_i    (key_word),
    .dir_i    (mode_q),
    .whiten_i (whiten),
    .nxt_o    (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= RC5_ENC;
    end else if (accept) begin
      mode_q <= rc5_dir_e'(in_mode);
      x_q    <= in_mode ? word_b : word_a;
      y_q    <= in_mode ? word_a : word_b;
    end else if (busy) begin
      x_q <= y_q;
      y_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_valid <= 1'b0;
    else if (accept)                 out_valid <= 1'b0;
    else if (last_step)              out_valid <= 1'b1;
    else if (out_valid && out_ready) out_valid <= 1'b0;
  end

  assign out_block = (mode_q == RC5_DEC) ? {x_q, y_q} : {y_q, x_q};
endmodule

// File: rtl/rc5_iter_core_sva.sv
module rc5_iter_core_sva #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       in_mode,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [2*WORD_W-1:0]        out_block,
  input logic [$clog2(2*ROUNDS+2)-1:0] key_idx
);
  localparam int STEPS = 2 * ROUNDS + 2;
  localparam int IDX_W = $clog2(STEPS);
  localparam int CW    = IDX_W + 1;
  localparam logic [CW-1:0] LAST_C  = CW'(STEPS - 1);
  localparam logic [CW-1:0] STEPS_C = CW'(STEPS);

  logic          active;
  logic          mode_c;
  logic [CW-1:0] cnt;
  logic          take;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_c <= 1'b0;
      cnt    <= '0;
    end else if (take) begin
      active <= 1'b1;
      mode_c <= in_mode;
      cnt    <= '0;
    end else if (active) begin
      if (out_valid) active <= 1'b0;
      else           cnt <= cnt + 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) $rose(rst_n) |-> (in_ready && !out_valid));

  p_accept_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!in_ready && !out_valid));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (active && cnt == STEPS_C));

  p_busy_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !out_valid) |-> !in_ready);

  p_key_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !out_valid) |-> ({1'b0, key_idx} == (mode_c ? (LAST_C - cnt) : cnt)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !take) |=> (out_valid && $stable(out_block)));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !take) |=> !out_valid);

  p_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> in_ready);
endmodule

bind rc5_iter_core rc5_iter_core_sva #(.WORD_W(WORD_W), .ROUNDS(ROUNDS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_block (out_block),
  .key_idx   (key_idx)
);

// File: tb/rc5_iter_core_bench.sv
`timescale 1ns/1ps
module rc5_iter_core_bench;
  localparam int NK = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [63:0] in_block = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_block;
  logic [4:0]  key_idx;
  logic [31:0] key_word;
  logic [31:0] s_tab [NK];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign key_word = (key_idx < 5'(NK)) ? s_tab[key_idx] : 32'h0;

  rc5_iter_core u_rc5_iter_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_block(in_block), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block), .key_idx(key_idx),
    .key_word(key_word)
  );

  function automatic logic [31:0] rotl(input logic [31:0] v, input logic [31:0] s);
    logic [4:0] k = s[4:0];
    return (k == 0) ? v : ((v << k) | (v >> (6'd32 - {1'b0, k})));
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [31:0] s);
    logic [4:0] k = s[4:0];
    return (k == 0) ? v : ((v >> k) | (v << (6'd32 - {1'b0, k})));
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] blk);
    logic [31:0] a = blk[31:0] + s_tab[0];
    logic [31:0] b = blk[63:32] + s_tab[1];
    for (int i = 1; i <= 12; i++) begin
      a = rotl(a ^ b, b) + s_tab[2*i];
      b = rotl(b ^ a, a) + s_tab[2*i+1];
    end
    return {b, a};
  endfunction

  function automatic logic [63:0] ref_dec(input logic [63:0] blk);
    logic [31:0] a = blk[31:0];
    logic [31:0] b = blk[63:32];
    for (int i = 12; i >= 1; i--) begin
      b = rotr(b - s_tab[2*i+1], a) ^ a;
      a = rotr(a - s_tab[2*i], b) ^ b;
    end
    b = b - s_tab[1];
    a = a - s_tab[0];
    return {b, a};
  endfunction

  task automatic expand_zero_key();
    logic [31:0] l [4];
    logic [31:0] ka, kb;
    int ii, jj;
    for (int q = 0; q < 4; q++) l[q] = '0;
    s_tab[0] = 32'hB7E15163;
    for (int q = 1; q < NK; q++) s_tab[q] = s_tab[q-1] + 32'h9E3779B9;
    ka = '0; kb = '0; ii = 0; jj = 0;
    for (int q = 0; q < 3*NK; q++) begin
      s_tab[ii] = rotl(s_tab[ii] + ka + kb, 32'd3);
      ka = s_tab[ii];
      l[jj] = rotl(l[jj] + ka + kb, ka + kb);
      kb = l[jj];
      ii = (ii + 1) % NK;
      jj = (jj + 1) % 4;
    end
  endtask

  task automatic random_keys();
    for (int q = 0; q < NK; q++) s_tab[q] = $urandom;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offers one block, follows it to completion, checks R4/R6/R10 on the way.
  task automatic run_block(input logic mode, input logic [63:0] blk, input bit junk,
                           input bit drain, output logic [63:0] res);
    int lat;
    int idx_bad;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_block = blk;
    @(posedge clk); #1;
    in_valid = 1'b0;
    lat = 0; idx_bad = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      if (key_idx !== (mode ? 5'(25 - lat) : 5'(lat))) idx_bad++;
      if (junk && lat == 4) begin
        in_valid = 1'b1; in_mode = ~mode; in_block = ~blk;
      end
      if (junk && lat == 9) in_valid = 1'b0;
      @(posedge clk); #1;
      lat++;
    end
    chk("R4 latency", 64'(lat), 64'd26);
    chk("R6 key index order mismatches", 64'(idx_bad), 64'd0);
    chk("R10 in_ready at completion", 64'(in_ready), 64'd1);
    res = out_block;
    if (drain) begin
      out_ready = 1'b1;
      @(posedge clk); #1;
      out_ready = 1'b0;
      chk("R8 out_valid after drain", 64'(out_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, r2, pt, ct, held;
    void'($urandom(32'd20240611));
    for (int q = 0; q < NK; q++) s_tab[q] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Published vector: all-zero 16-byte key, zero plaintext
    expand_zero_key();
    run_block(1'b0, 64'h0, 1'b0, 1'b1, r);
    chk("R2 known vector encrypt", r, 64'h6D8F4B15_EEDBA521);
    run_block(1'b1, r, 1'b0, 1'b1, r2);
    chk("R3 known vector decrypt", r2, 64'h0);

    // R5: offers while busy with altered data and mode are ignored
    random_keys();
    pt = {$urandom, $urandom};
    run_block(1'b0, pt, 1'b1, 1'b1, r);
    chk("R5 encrypt with offers while busy", r, ref_enc(pt));
    run_block(1'b1, r, 1'b1, 1'b1, r2);
    chk("R5 decrypt with offers while busy", r2, pt);

    // R7: controlling words whose upper bits are set, low 5 bits 0 or 31
    pt = {32'hFFFF_FFE0, 32'h8000_0000};
    run_block(1'b0, pt, 1'b0, 1'b1, r);
    chk("R7 rotate low bits zero encrypt", r, ref_enc(pt));
    pt = {32'h7FFF_FFFF, 32'hFFFF_FFFF};
    run_block(1'b1, pt, 1'b0, 1'b1, r);
    chk("R7 rotate low bits all ones decrypt", r, ref_dec(pt));
    for (int q = 0; q < NK; q++) s_tab[q] = 32'hAAAA_AA00 | 32'(q << 5);
    pt = {32'h1234_5600, 32'hABCD_EF20};
    run_block(1'b0, pt, 1'b0, 1'b1, r);
    chk("R7 key words with zero low bits", r, ref_enc(pt));

    // R8: result held while out_ready is low
    random_keys();
    pt = {$urandom, $urandom};
    run_block(1'b0, pt, 1'b0, 1'b0, r);
    held = out_block;
    repeat (8) @(posedge clk);
    #1;
    chk("R8 out_valid held", 64'(out_valid), 64'd1);
    chk("R8 out_block stable", out_block, held);
    chk("R2 held result value", out_block, ref_enc(pt));

    // R9: new accept clears pending result
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b1; in_block = held;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9 pending out_valid cleared on accept", 64'(out_valid), 64'd0);
    while (!out_valid) @(posedge clk);
    #1;
    chk("R3 decrypt after overwrite", out_block, pt);
    out_ready = 1'b1; @(posedge clk); #1; out_ready = 1'b0;

    // Random round trips, key table refreshed every few blocks
    for (int t = 0; t < 24; t++) begin
      if (t % 4 == 0) random_keys();
      pt = {$urandom, $urandom};
      run_block(1'b0, pt, 1'b0, 1'b1, ct);
      chk("R2 random encrypt", ct, ref_enc(pt));
      run_block(1'b1, ct, 1'b0, 1'b1, r);
      chk("R3 random decrypt", r, pt);
      run_block(1'b1, pt, 1'b0, 1'b1, r);
      chk("R3 random decrypt of arbitrary block", r, ref_dec(pt));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule